// File: doc/BRIEF.md
# Video Memory Row-Transfer Controller

This block models a dual-port video memory built around a square bit array and a serial shift chain that is as long as one array row. A host drives an active-low strobe interface (row strobe, column strobe, write enable, transfer enable and an address bus) to start transfer cycles. Each cycle moves a complete row at once, either from the array into the chain or from the chain back into the array. A display engine, running on its own serial clock, shifts bits in and out of the chain. The serial output can be released to high impedance so that several banks can share one line.

All strobes and the serial clock are asynchronous. The block samples them into one system clock and acts on the edges it detects there. The row strobe falling edge opens a cycle and latches the request, the direction and the row. The column strobe can update a segment selector during the cycle. The move itself takes place when the row strobe returns high. The segment selector chooses which quarter of the chain feeds the serial output after a load. Serial data is refused until the first transfer has completed after reset. A serial clock edge that arrives while a cycle is open is deferred until the cycle has closed.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: A row is moved only when transfer enable (`xfer_en_n`) is low at the row strobe fall. If it is high, neither the array nor the chain changes.
- R2: The row address used by a transfer is the low `clog2(ROWS)` bits of `addr`, captured at the row strobe fall.
- R3: If `wr_en_n` is low at the row strobe fall, the chain is copied into the chosen row, with chain bit i going to row bit i. If `wr_en_n` is high, the row is copied into the chain.
- R4: The top two bits of `addr`, captured at the column strobe fall, form a segment number s in 0..3. After a load, `ser_out` first shows chain bit CHAIN_LEN-1-s*CHAIN_LEN/4, and each shift then presents the next lower bit.
- R5: Without a new column strobe fall, the segment number keeps its last value across any number of cycles.
- R6: The chain is CHAIN_LEN flops in series. On each accepted serial clock rise, `ser_in` enters bit 0 and every bit moves one place up. With segment 0, a bit entered on shift j appears at `ser_out` after shift j+CHAIN_LEN-1.
- R7: After a row-to-chain load, `ser_out` shows the new data within a few system clocks of the row strobe rise, with no serial clock edge.
- R8: While `ser_oe_n` is high, `ser_out` is released to high impedance. While it is low, it drives the chain output bit.
- R9: From reset until the first transfer completes, serial data is ignored: the chain stays all-zero, whatever arrives on `ser_in`.
- R10: A serial clock rise that arrives while the row strobe is low is held. It takes effect exactly once after the row strobe rises, following any load, so a load and a shift never fall in the same system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Row strobe, active low, asynchronous |
| col_stb_n | input | 1 | Column strobe, active low, asynchronous |
| wr_en_n | input | 1 | Direction: low moves chain to array, high moves array to chain |
| xfer_en_n | input | 1 | Transfer request, active low, sampled at row strobe fall |
| addr | input | clog2(ROWS) | Row address; upper two bits give the segment |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_in | input | 1 | Serial data in |
| ser_oe_n | input | 1 | Serial output enable, active low |
| ser_out | output | 1 | Serial data out, high impedance when disabled |

## Verification
The bench builds the block with ROWS=8, CHAIN_LEN=16 and four segments. With these values every row can be written with its own computed pattern, and every row can then be read back in every segment, each bit of each readout compared against a value the bench derives from the pattern. The short chain also keeps the full wrap of entered bits to the output within reach, as well as the deferred serial edge around a load, the power-up refusal, and transfer-enable-high cycles in both directions.

// File: rtl/vx_pkg.sv
package vx_pkg;
  // First chain bit presented at the serial output after a load from segment sel.
  function automatic int seg_tap(input int sel, input int chain_len, input int segs);
    return chain_len - 1 - sel * (chain_len / segs);
  endfunction
endpackage

// File: rtl/vx_edge_sync.sv
module vx_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_o,
  output logic lvl_d_o
);
  logic [STAGES-1:0] pipe_q;
  logic              dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
      dly_q  <= RST_VAL;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], async_i};
      dly_q  <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o   = pipe_q[STAGES-1];
  assign lvl_d_o = dly_q;
endmodule

// File: rtl/vx_cycle_latch.sv
module vx_cycle_latch #(
  parameter int ADDR_W = 8,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_fall,
  input  logic              col_fall,
  input  logic              xfer_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              xfer_q,
  output logic              to_chain_q,
  output logic [ADDR_W-1:0] row_q,
  output logic [SEG_W-1:0]  seg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q     <= 1'b0;
      to_chain_q <= 1'b0;
      row_q      <= '0;
    end else if (row_fall) begin
      xfer_q     <= ~xfer_en_n;
      to_chain_q <= wr_en_n;
      row_q      <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seg_q <= '0;
    else if (col_fall) seg_q <= addr[ADDR_W-1 -: SEG_W];
  end
endmodule

// File: rtl/vx_row_store.sv
module vx_row_store #(
  parameter int ROWS  = 256,
  parameter int WIDTH = 256,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             wr_i,
  input  logic [RW-1:0]    row_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (wr_i) mem_q[row_i] <= wdata_i;
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/vx_shift_chain.sv
module vx_shift_chain #(
  parameter int CHAIN_LEN = 256,
  parameter int SEGS      = 4,
  localparam int SEG_W    = $clog2(SEGS),
  localparam int TAP_W    = $clog2(CHAIN_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [CHAIN_LEN-1:0] load_data_i,
  input  logic [SEG_W-1:0]     seg_i,
  input  logic                 shift_i,
  input  logic                 shift_bit_i,
  output logic [CHAIN_LEN-1:0] chain_o,
  output logic                 tap_bit_o
);
  logic [CHAIN_LEN-1:0] chain_q;
  logic [TAP_W-1:0]     tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      tap_q   <= TAP_W'(CHAIN_LEN - 1);
    end else if (load_i) begin
      chain_q <= load_data_i;
      tap_q   <= TAP_W'(vx_pkg::seg_tap(int'(seg_i), CHAIN_LEN, SEGS));
    end else if (shift_i) begin
      chain_q <= {chain_q[CHAIN_LEN-2:0], shift_bit_i};
    end
  end

  assign chain_o   = chain_q;
  assign tap_bit_o = chain_q[tap_q];
endmodule

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl #(
  parameter int ROWS        = 256,
  parameter int CHAIN_LEN   = 256,
  parameter int SEGS        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(ROWS),
  localparam int SEG_W      = $clog2(SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              wr_en_n,
  input  logic              xfer_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ser_clk,
  input  logic              ser_in,
  input  logic              ser_oe_n,
  output wire               ser_out
);
  localparam int         NSYNC    = 3;
  localparam logic [2:0] SYNC_RST = 3'b011;

  logic [NSYNC-1:0] async_in, lvl, lvl_d;
  assign async_in = {ser_clk, col_stb_n, row_stb_n};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    vx_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(async_in[g]),
      .lvl_o(lvl[g]), .lvl_d_o(lvl_d[g]));
  end

  // Named events for the checker.
  logic row_lvl, row_fall, row_rise, col_fall, ser_rise;
  assign row_lvl  = lvl[0];
  assign row_fall = lvl_d[0] & ~lvl[0];
  assign row_rise = ~lvl_d[0] & lvl[0];
  assign col_fall = lvl_d[1] & ~lvl[1];
  assign ser_rise = ~lvl_d[2] & lvl[2];

  logic [1:0] sin_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sin_q <= '0;
    else        sin_q <= {sin_q[0], ser_in};
  end

  logic              xfer_q, to_chain_q;
  logic [ADDR_W-1:0] row_q;
  logic [SEG_W-1:0]  seg_q;

  vx_cycle_latch #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .row_fall(row_fall), .col_fall(col_fall),
    .xfer_en_n(xfer_en_n), .wr_en_n(wr_en_n), .addr(addr),
    .xfer_q(xfer_q), .to_chain_q(to_chain_q), .row_q(row_q), .seg_q(seg_q));

  logic load_evt, store_evt, shift_evt, shift_pend_q, armed_q, row_busy;
  assign load_evt  = row_rise & xfer_q & to_chain_q;
  assign store_evt = row_rise & xfer_q & ~to_chain_q;
  assign row_busy  = ~row_lvl | row_rise;
  assign shift_evt = (ser_rise | shift_pend_q) & ~row_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_pend_q <= 1'b0;
      armed_q      <= 1'b0;
    end else begin
      if (shift_evt)     shift_pend_q <= 1'b0;
      else if (ser_rise) shift_pend_q <= 1'b1;
      if (load_evt | store_evt) armed_q <= 1'b1;
    end
  end

  logic [CHAIN_LEN-1:0] chain, row_data;
  logic                 tap_bit;

  vx_row_store #(.ROWS(ROWS), .WIDTH(CHAIN_LEN)) u_store (
    .clk(clk), .wr_i(store_evt), .row_i(row_q),
    .wdata_i(chain), .rdata_o(row_data));

  vx_shift_chain #(.CHAIN_LEN(CHAIN_LEN), .SEGS(SEGS)) u_chain (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .load_data_i(row_data),
    .seg_i(seg_q), .shift_i(shift_evt), .shift_bit_i(armed_q & sin_q[1]),
    .chain_o(chain), .tap_bit_o(tap_bit));

  assign ser_out = ser_oe_n ? 1'bz : tap_bit;
endmodule

// File: rtl/vx_xfer_checker.sv
module vx_xfer_checker #(
  parameter int SEG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_oe_n,
  input logic             ser_out,
  input logic             tap_bit,
  input logic             row_lvl,
  input logic             row_rise,
  input logic             col_fall,
  input logic             xfer_q,
  input logic             load_evt,
  input logic             store_evt,
  input logic             shift_evt,
  input logic             armed_q,
  input logic [SEG_W-1:0] seg_q
);
  AST_XFER_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt || store_evt) |-> xfer_q); // R1
  AST_XFER_AT_ROW_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt || store_evt) |-> row_rise); // R7
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load_evt, store_evt}) <= 1); // R3
  AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !col_fall |=> $stable(seg_q)); // R5
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe_n && tap_bit) |-> (ser_out !== 1'b1)); // R8
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !tap_bit); // R9
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R9
  AST_SHIFT_NOT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> (row_lvl && !row_rise && !load_evt)); // R10
endmodule

bind vram_xfer_ctrl vx_xfer_checker #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_oe_n(ser_oe_n), .ser_out(ser_out),
  .tap_bit(tap_bit), .row_lvl(row_lvl), .row_rise(row_rise),
  .col_fall(col_fall), .xfer_q(xfer_q), .load_evt(load_evt),
  .store_evt(store_evt), .shift_evt(shift_evt), .armed_q(armed_q),
  .seg_q(seg_q));

// File: tb/sim_vram_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_vram_xfer_ctrl;
  localparam int ROWS = 8;
  localparam int N    = 16;
  localparam int SEGS = 4;
  localparam int AW   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_n = 1'b1, col_n = 1'b1, we_n = 1'b1, xen_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic sclk = 1'b0, sin = 1'b0, oe_n = 1'b0;
  wire  sout;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  vram_xfer_ctrl #(.ROWS(ROWS), .CHAIN_LEN(N), .SEGS(SEGS)) u0 (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_n), .col_stb_n(col_n),
    .wr_en_n(we_n), .xfer_en_n(xen_n), .addr(addr), .ser_clk(sclk),
    .ser_in(sin), .ser_oe_n(oe_n), .ser_out(sout));

  function automatic logic [N-1:0] pat(input int r);
    return N'((r * 937) ^ 16'hA6C9 ^ (r << 11));
  endfunction

  function automatic int first_bit(input int s);
    return N - 1 - s * (N / SEGS);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser_pulse(input logic b);
    sin = b; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
  endtask

  // One strobed cycle; to_chain=1 moves row to chain.
  task automatic cycle(input bit en, input bit to_chain, input int row,
                       input bit set_seg, input int seg, input bit pulse_mid);
    addr = AW'(row); xen_n = ~en; we_n = to_chain; tick(2);
    row_n = 1'b0; tick(5);
    if (set_seg) begin
      addr = AW'(seg << 1); col_n = 1'b0; tick(5); col_n = 1'b1;
    end
    if (pulse_mid) ser_pulse(1'b1);
    tick(3); row_n = 1'b1; tick(6); xen_n = 1'b1;
  endtask

  task automatic fill_row(input int r, input logic [N-1:0] p);
    for (int j = 1; j <= N; j++) ser_pulse(p[N-j]);
    cycle(1'b1, 1'b0, r, 1'b0, 0, 1'b0);
  endtask

  // Checks the readout of pattern p from bit 'tap' downward (R4, R7).
  task automatic read_out(input logic [N-1:0] p, input int tap, input string req);
    for (int k = 0; k <= tap; k++) begin
      chk(sout === p[tap-k], req, int'(sout), int'(p[tap-k]));
      if (k < tap) ser_pulse(1'b0);
    end
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(3);
    // Reset state and R9: serial data refused before any transfer.
    chk(sout === 1'b0, "R9 reset output", int'(sout), 0);
    for (int j = 0; j < N; j++) begin
      ser_pulse(1'b1);
      chk(sout === 1'b0, "R9 disarmed shift", int'(sout), 0);
    end
    cycle(1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
    cycle(1'b1, 1'b1, 0, 1'b1, 0, 1'b0);
    read_out('0, N - 1, "R9 row holds zeros");

    // R2/R3: every row written with its own pattern.
    for (int r = 0; r < ROWS; r++) fill_row(r, pat(r));
    // R4/R7: every row read back in every segment.
    for (int r = 0; r < ROWS; r++)
      for (int s = 0; s < SEGS; s++) begin
        cycle(1'b1, 1'b1, r, 1'b1, s, 1'b0);
        read_out(pat(r), first_bit(s), "R4 R7 R2 R3 readout");
      end

    // R5: segment 3 kept across a cycle with no column strobe.
    cycle(1'b1, 1'b1, 2, 1'b1, 3, 1'b0);
    cycle(1'b1, 1'b1, 5, 1'b0, 0, 1'b0);
    read_out(pat(5), first_bit(3), "R5 segment held");

    // R1: transfer enable high blocks both directions.
    for (int j = 0; j < N; j++) ser_pulse(1'b1);
    cycle(1'b0, 1'b0, 1, 1'b0, 0, 1'b0);
    chk(sout === 1'b1, "R1 no store chain kept", int'(sout), 1);
    cycle(1'b0, 1'b1, 2, 1'b0, 0, 1'b0);
    chk(sout === 1'b1, "R1 no load chain kept", int'(sout), 1);
    // R8: output released while disabled, driven while enabled.
    oe_n = 1'b1; tick(2);
    chk(sout !== 1'b1, "R8 released", int'(sout), 0);
    oe_n = 1'b0; tick(2);
    chk(sout === 1'b1, "R8 driven", int'(sout), 1);
    cycle(1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
    read_out(pat(1), N - 1, "R1 row unchanged");

    // R6: full chain length with segment 0.
    begin
      logic [2*N-1:0] q;
      q = {pat(3), pat(6)};
      cycle(1'b1, 1'b1, 4, 1'b1, 0, 1'b0);
      for (int k = 1; k <= 2 * N; k++) begin
        ser_pulse(q[k-1]);
        if (k < N)
          chk(sout === pat(4)[N-1-k], "R6 old bits", int'(sout), int'(pat(4)[N-1-k]));
        else
          chk(sout === q[k-N], "R6 entered bit", int'(sout), int'(q[k-N]));
      end
    end

    // R10: serial edge during an open cycle applied once, after the load.
    cycle(1'b1, 1'b1, 6, 1'b1, 0, 1'b1);
    chk(sout === pat(6)[N-2], "R10 deferred shift", int'(sout), int'(pat(6)[N-2]));
    tick(10);
    chk(sout === pat(6)[N-2], "R10 single shift", int'(sout), int'(pat(6)[N-2]));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule